// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits behind a translation lookup and decides whether one memory access to an already matched page may go ahead. Each request carries the effective address, the access kind, the privilege of the requester, a flag marking the access as speculative, the current address-space identifier and the attributes of the matched page entry. The block returns a registered verdict: a fault flag with a cause code, plus the cache-enable and write-policy attributes that the access should use.

Before any page-level check, a bank of sixteen two-bit segment fields is consulted. The field is chosen by the top four bits of the effective address, which are the top bits of the page number. A mode input decides how the field is read. In key mode it gives a protection key for each privilege level. In domain mode it can leave the page rules in force, block the segment entirely or open it completely. Separate enables for instruction and data traffic switch the whole check off. A request is then let through with default attributes.

Top module: `page_perm_checker`

## Requirements
- R1: The segment bank holds 16 independent 2-bit fields. A config write with `cfg_wr_en` high replaces field `cfg_wr_idx` with `cfg_wr_data` on that clock edge. A request uses the field indexed by `req_addr[ADDR_W-1 -: 4]`.
- R2: In key mode (`cfg_domain_mode`=0), field bit 0 is the supervisor key and bit 1 is the user key. The key of the requester's level is the one that applies. When that key is 1, the page is treated as read-only, so a write faults with cause 4.
- R3: In domain mode (`cfg_domain_mode`=1), field 00 leaves the page rules in force. Fields 01 and 10 block every access with cause 2. Field 11 grants the access and skips the privilege, read/write and guard checks.
- R4: `pg_priv` 00 means supervisor only, 01 means user only, and 10 or 11 means both levels. An access from a level the page excludes faults with cause 3.
- R5: `req_kind` 00 is a read, 01 a write, 10 an instruction fetch and 11 is treated as a read. A read or fetch with `pg_rd`=0, or a write with `pg_wr`=0, faults with cause 4.
- R6: When `pg_asid_chk`=1 and `pg_asid` differs from `cur_asid`, the entry does not match and the access faults with cause 1.
- R7: A speculative access (`req_spec`=1) to a guarded page (`pg_guard`=1) faults with cause 5. A speculative access to an unguarded page is not refused for that reason.
- R8: A permitted checked access returns `rsp_cache_en`=`pg_cache_en` and `rsp_wthru`=`pg_wthru`. A faulting access returns both as 0.
- R9: A fetch while `cfg_ifetch_en`=0, or a read or write while `cfg_data_en`=0, is permitted with cause 0, `rsp_cache_en`=0 and `rsp_wthru`=0, whatever the page says. Each enable affects only its own kind of traffic.
- R10: When several faults apply, the reported cause is the first one present in this order: 1 no match, 2 group block, 3 privilege, 4 read/write, 5 guard. Cause 0 means permitted, and `rsp_fault` is 1 exactly when the cause is nonzero.
- R11: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. The result outputs keep their values in cycles without a request.
- R12: After a synchronous active-low reset, `rsp_valid`, `rsp_fault`, `rsp_cause`, `rsp_cache_en` and `rsp_wthru` are 0 and every segment field is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for a segment field |
| cfg_wr_idx | input | 4 | Segment field to write |
| cfg_wr_data | input | 2 | New field value |
| cfg_domain_mode | input | 1 | 0 key mode, 1 domain mode |
| cfg_ifetch_en | input | 1 | Checks enabled for instruction fetches |
| cfg_data_en | input | 1 | Checks enabled for reads and writes |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Effective address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_super | input | 1 | 1 supervisor, 0 user |
| req_spec | input | 1 | Access is speculative |
| cur_asid | input | ASID_W | Current address-space identifier |
| pg_asid | input | ASID_W | Identifier held in the page entry |
| pg_asid_chk | input | 1 | Entry requires an identifier match |
| pg_priv | input | 2 | Privilege setting of the page |
| pg_rd | input | 1 | Page readable |
| pg_wr | input | 1 | Page writable |
| pg_guard | input | 1 | Page guarded against speculative access |
| pg_cache_en | input | 1 | Page cacheable |
| pg_wthru | input | 1 | Page write-through (0 write-back) |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 3 | Fault cause code (0 permitted) |
| rsp_cache_en | output | 1 | Effective cache enable |
| rsp_wthru | output | 1 | Effective write-through policy |

## Verification
On every cycle, the assertions check several rules. The response strobe must follow the request strobe by one cycle. A written segment field must take the written value. The fault flag must agree with the cause code. A faulting response must carry no cache attributes. An identifier mismatch on a checked entry must win over every other cause. A disabled data path must never fault. The key and domain interpretations of the segment fields, the privilege encodings and the full priority ordering can only be shown by the bench's scenarios. Those scenarios combine field contents written earlier with particular addresses and page attributes, and compare the results against a separately computed model.

// File: rtl/page_perm_pkg.sv
// Shared encodings for the page access permission checker.
// Assumes: cause codes are ordered by reporting priority.
package page_perm_pkg;

    typedef enum logic [2:0] {
        CAUSE_OK      = 3'd0,
        CAUSE_NOMATCH = 3'd1,
        CAUSE_GROUP   = 3'd2,
        CAUSE_PRIV    = 3'd3,
        CAUSE_RW      = 3'd4,
        CAUSE_GUARD   = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_e;

    localparam logic [1:0] DOM_NORMAL = 2'b00;
    localparam logic [1:0] DOM_FREE   = 2'b11;

    localparam logic [1:0] PRIV_SUPER = 2'b00;
    localparam logic [1:0] PRIV_USER  = 2'b01;

    typedef struct packed {
        cause_e cause;
        logic   cache_en;
        logic   wthru;
    } verdict_t;

endpackage

// File: rtl/seg_field_bank.sv
// Bank of per-segment protection fields.
// What it does: stores NUM_FIELDS fields of FIELD_W bits, each written by
// index, and returns the field selected by rd_idx combinationally.
// Assumes: one write per cycle; a read in the same cycle as a write to the
// same field sees the old value.
module seg_field_bank #(
    parameter int NUM_FIELDS = 16,
    parameter int FIELD_W    = 2,
    localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FIELD_W-1:0] rd_data
);

    logic [FIELD_W-1:0] fld_q [NUM_FIELDS];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        // Holds one field; cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                fld_q[g] <= wr_data;
            end
        end
    end

    // Selects the field for the current request.
    always_comb begin
        rd_data = fld_q[rd_idx];
    end

    // R1: a written field holds the written value on the next cycle.
    p_field_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fld_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/perm_eval.sv
// Combinational permission decision for one access.
// What it does: combines the segment field (as a key pair or a domain
// override), the page entry attributes and the request to produce a
// prioritized cause code and the effective cache attributes.
// Assumes: inputs are stable during the cycle in which they are sampled.
module perm_eval
    import page_perm_pkg::*;
#(
    parameter int ASID_W  = 4,
    parameter int FIELD_W = 2
) (
    input  logic               domain_mode,
    input  logic               ifetch_en,
    input  logic               data_en,
    input  logic [FIELD_W-1:0] seg_field,
    input  logic [1:0]         kind,
    input  logic               is_super,
    input  logic               is_spec,
    input  logic [ASID_W-1:0]  cur_asid,
    input  logic [ASID_W-1:0]  pg_asid,
    input  logic               pg_asid_chk,
    input  logic [1:0]         pg_priv,
    input  logic               pg_rd,
    input  logic               pg_wr,
    input  logic               pg_guard,
    input  logic               pg_cache_en,
    input  logic               pg_wthru,
    output verdict_t           verdict
);

    logic is_fetch, is_write, checks_on;
    logic sel_key, key_ro, grp_block, grp_free;
    logic miss, priv_bad, rw_bad, guard_bad;

    // Classifies the access and picks the enable that governs it.
    always_comb begin
        is_fetch  = (kind == KIND_FETCH);
        is_write  = (kind == KIND_WRITE);
        checks_on = is_fetch ? ifetch_en : data_en;
    end

    // Interprets the segment field as a key pair or as a domain override.
    always_comb begin
        sel_key   = is_super ? seg_field[0] : seg_field[1];
        key_ro    = !domain_mode && sel_key;
        grp_free  = domain_mode && (seg_field == DOM_FREE);
        grp_block = domain_mode && (seg_field != DOM_FREE)
                                && (seg_field != DOM_NORMAL);
    end

    // Evaluates each page-level fault condition separately.
    always_comb begin
        miss      = pg_asid_chk && (pg_asid != cur_asid);
        priv_bad  = !grp_free &&
                    (((pg_priv == PRIV_SUPER) && !is_super) ||
                     ((pg_priv == PRIV_USER)  &&  is_super));
        rw_bad    = !grp_free &&
                    (is_write ? (!pg_wr || key_ro) : !pg_rd);
        guard_bad = !grp_free && is_spec && pg_guard;
    end

    // Reports the highest-priority fault and the resulting attributes.
    always_comb begin
        verdict.cache_en = 1'b0;
        verdict.wthru    = 1'b0;
        if (!checks_on) begin
            verdict.cause = CAUSE_OK;
        end else if (miss) begin
            verdict.cause = CAUSE_NOMATCH;
        end else if (grp_block) begin
            verdict.cause = CAUSE_GROUP;
        end else if (priv_bad) begin
            verdict.cause = CAUSE_PRIV;
        end else if (rw_bad) begin
            verdict.cause = CAUSE_RW;
        end else if (guard_bad) begin
            verdict.cause = CAUSE_GUARD;
        end else begin
            verdict.cause    = CAUSE_OK;
            verdict.cache_en = pg_cache_en;
            verdict.wthru    = pg_wthru;
        end
    end

    // R8: a fault never carries cache attributes.
    always_comb begin
        if (verdict.cause != CAUSE_OK) begin
            a_fault_no_attr_r8: assert (!verdict.cache_en && !verdict.wthru);
        end
    end

endmodule

// File: rtl/page_perm_checker.sv
// Page access permission checker, top level.
// What it does: selects a segment field from the top address bits, runs the
// permission decision and registers the verdict one cycle after a request.
// Assumes: the page entry presented with a request is the one the
// translation lookup matched for that address.
module page_perm_checker
    import page_perm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ASID_W     = 4,
    parameter int NUM_FIELDS = 16,
    parameter int FIELD_W    = 2,
    localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [IDX_W-1:0]   cfg_wr_idx,
    input  logic [FIELD_W-1:0] cfg_wr_data,
    input  logic               cfg_domain_mode,
    input  logic               cfg_ifetch_en,
    input  logic               cfg_data_en,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_kind,
    input  logic               req_super,
    input  logic               req_spec,
    input  logic [ASID_W-1:0]  cur_asid,
    input  logic [ASID_W-1:0]  pg_asid,
    input  logic               pg_asid_chk,
    input  logic [1:0]         pg_priv,
    input  logic               pg_rd,
    input  logic               pg_wr,
    input  logic               pg_guard,
    input  logic               pg_cache_en,
    input  logic               pg_wthru,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [2:0]         rsp_cause,
    output logic               rsp_cache_en,
    output logic               rsp_wthru
);

    logic [IDX_W-1:0]   seg_idx;
    logic [FIELD_W-1:0] seg_field;
    verdict_t           verdict;
    logic               unused_low_addr;

    // Takes the segment index from the top page-number bits.
    always_comb begin
        seg_idx         = req_addr[ADDR_W-1 -: IDX_W];
        unused_low_addr = ^req_addr[ADDR_W-IDX_W-1:0];
    end

    seg_field_bank #(
        .NUM_FIELDS (NUM_FIELDS),
        .FIELD_W    (FIELD_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (seg_idx),
        .rd_data (seg_field)
    );

    perm_eval #(
        .ASID_W  (ASID_W),
        .FIELD_W (FIELD_W)
    ) u_eval (
        .domain_mode (cfg_domain_mode),
        .ifetch_en   (cfg_ifetch_en),
        .data_en     (cfg_data_en),
        .seg_field   (seg_field),
        .kind        (req_kind),
        .is_super    (req_super),
        .is_spec     (req_spec),
        .cur_asid    (cur_asid),
        .pg_asid     (pg_asid),
        .pg_asid_chk (pg_asid_chk),
        .pg_priv     (pg_priv),
        .pg_rd       (pg_rd),
        .pg_wr       (pg_wr),
        .pg_guard    (pg_guard),
        .pg_cache_en (pg_cache_en),
        .pg_wthru    (pg_wthru),
        .verdict     (verdict)
    );

    // Marks the cycle after each request as carrying a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
        end
    end

    // Captures the verdict on a request and holds it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault    <= 1'b0;
            rsp_cause    <= CAUSE_OK;
            rsp_cache_en <= 1'b0;
            rsp_wthru    <= 1'b0;
        end else if (req_valid) begin
            rsp_fault    <= (verdict.cause != CAUSE_OK);
            rsp_cause    <= verdict.cause;
            rsp_cache_en <= verdict.cache_en;
            rsp_wthru    <= verdict.wthru;
        end
    end

    // R11: the result strobe follows the request strobe by one cycle.
    p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_without_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11: the result holds in cycles without a request.
    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_cause) && $stable(rsp_cache_en)));

    // R10: the fault flag agrees with the cause code.
    p_fault_matches_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

    // R8: a refused access carries no cache attributes.
    p_fault_attr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!rsp_cache_en && !rsp_wthru));

    // R6: an identifier mismatch on a checked data access wins.
    p_nomatch_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_data_en && (req_kind != 2'b10) && pg_asid_chk
         && (pg_asid != cur_asid)) |=> (rsp_cause == 3'd1));

    // R9: a data access with data checks off never faults.
    p_data_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_data_en && (req_kind != 2'b10))
        |=> (!rsp_fault && !rsp_cache_en));

endmodule

// File: tb/page_perm_checker_tb.sv
`timescale 1ns/1ps
module page_perm_checker_tb;

    localparam int ADDR_W = 32;
    localparam int ASID_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [3:0]        cfg_wr_idx = '0;
    logic [1:0]        cfg_wr_data = '0;
    logic              cfg_domain_mode = 1'b0;
    logic              cfg_ifetch_en = 1'b1;
    logic              cfg_data_en = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_kind = '0;
    logic              req_super = 1'b0;
    logic              req_spec = 1'b0;
    logic [ASID_W-1:0] cur_asid = '0;
    logic [ASID_W-1:0] pg_asid = '0;
    logic              pg_asid_chk = 1'b0;
    logic [1:0]        pg_priv = 2'b10;
    logic              pg_rd = 1'b1;
    logic              pg_wr = 1'b1;
    logic              pg_guard = 1'b0;
    logic              pg_cache_en = 1'b1;
    logic              pg_wthru = 1'b0;
    logic              rsp_valid, rsp_fault, rsp_cache_en, rsp_wthru;
    logic [2:0]        rsp_cause;

    int errors = 0;
    int checks = 0;
    logic [1:0] model_fld [16];

    always #4 clk = ~clk;

    page_perm_checker #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_domain_mode(cfg_domain_mode), .cfg_ifetch_en(cfg_ifetch_en),
        .cfg_data_en(cfg_data_en), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_super(req_super), .req_spec(req_spec),
        .cur_asid(cur_asid), .pg_asid(pg_asid), .pg_asid_chk(pg_asid_chk),
        .pg_priv(pg_priv), .pg_rd(pg_rd), .pg_wr(pg_wr), .pg_guard(pg_guard),
        .pg_cache_en(pg_cache_en), .pg_wthru(pg_wthru),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_cache_en(rsp_cache_en), .rsp_wthru(rsp_wthru)
    );

    // Reference model written from the requirements: {cause, cache_en, wthru}.
    function automatic logic [4:0] expect_of();
        logic [1:0] f;
        logic fetch, wr, on, key, free, blk;
        logic [2:0] c;
        f     = model_fld[req_addr[31:28]];
        fetch = (req_kind == 2'b10);
        wr    = (req_kind == 2'b01);
        on    = fetch ? cfg_ifetch_en : cfg_data_en;            // R9
        key   = req_super ? f[0] : f[1];                        // R2
        free  = cfg_domain_mode && f == 2'b11;                  // R3
        blk   = cfg_domain_mode && (f == 2'b01 || f == 2'b10);  // R3
        if (!on) return 5'b0;
        if (pg_asid_chk && pg_asid != cur_asid) c = 3'd1;       // R6
        else if (blk) c = 3'd2;
        else if (!free && ((pg_priv == 2'b00 && !req_super) ||
                           (pg_priv == 2'b01 && req_super))) c = 3'd3;  // R4
        else if (!free && (wr ? (!pg_wr || (!cfg_domain_mode && key))
                              : !pg_rd)) c = 3'd4;              // R5
        else if (!free && req_spec && pg_guard) c = 3'd5;       // R7
        else c = 3'd0;
        if (c != 0) return {c, 2'b00};                          // R8
        return {c, pg_cache_en, pg_wthru};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_field(input int idx, input logic [1:0] val);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = 4'(idx); cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_fld[idx] = val;
    endtask

    // Issues one request and compares {fault, cause, cache_en, wthru}.
    task automatic do_req(input string req);
        logic [4:0] e;
        @(negedge clk);
        e = expect_of();
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {rsp_fault, rsp_cause, rsp_cache_en, rsp_wthru},
              {(e[4:2] != 0), e});
        checks++;
        if (rsp_valid !== 1'b1) begin
            errors++;
            $display("FAIL R11: rsp_valid actual=%b expected=1", rsp_valid);
        end
    endtask

    task automatic page(input logic [1:0] pr, input logic rd, input logic wr,
                        input logic gd, input logic ce, input logic wt);
        pg_priv = pr; pg_rd = rd; pg_wr = wr; pg_guard = gd;
        pg_cache_en = ce; pg_wthru = wt;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] held;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) model_fld[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state of outputs.
        check("R12", {rsp_valid, rsp_fault, rsp_cause, rsp_cache_en},
              6'b0);
        // R12: fields reset to 00: domain mode lets a normal access through.
        cfg_domain_mode = 1'b1;
        req_addr = 32'h7000_0000; req_kind = 2'b00; req_super = 1'b0;
        page(2'b10, 1, 1, 0, 1, 1);
        do_req("R12");

        // R1/R3: field 5 blocks, field 6 untouched.
        write_field(5, 2'b01);
        req_addr = 32'h5000_1234; do_req("R1");
        req_addr = 32'h6000_1234; do_req("R1");
        write_field(6, 2'b10);
        do_req("R3");
        // R3: free access overrides privilege, write and guard.
        write_field(6, 2'b11);
        page(2'b00, 0, 0, 1, 1, 1);
        req_kind = 2'b01; req_super = 1'b0; req_spec = 1'b1;
        do_req("R3");
        req_spec = 1'b0;

        // R2: key mode, user key set on segment 3.
        cfg_domain_mode = 1'b0;
        write_field(3, 2'b10);
        page(2'b10, 1, 1, 0, 1, 0);
        req_addr = 32'h3000_0000; req_kind = 2'b01; req_super = 1'b0;
        do_req("R2");
        req_super = 1'b1; do_req("R2");
        req_kind = 2'b00; req_super = 1'b0; do_req("R2");

        // R4: privilege encodings.
        req_addr = 32'h1000_0000;
        page(2'b00, 1, 1, 0, 1, 0); req_super = 1'b0; do_req("R4");
        page(2'b01, 1, 1, 0, 1, 0); req_super = 1'b1; do_req("R4");
        page(2'b11, 1, 1, 0, 1, 0); req_super = 1'b0; do_req("R4");

        // R5: read protection on read, fetch, and reserved kind.
        page(2'b10, 0, 1, 0, 1, 0);
        req_kind = 2'b00; do_req("R5");
        req_kind = 2'b10; do_req("R5");
        req_kind = 2'b11; do_req("R5");
        page(2'b10, 1, 0, 0, 1, 0); req_kind = 2'b01; do_req("R5");

        // R6: mismatch outranks a group block.
        cfg_domain_mode = 1'b1;
        pg_asid_chk = 1'b1; pg_asid = 4'h3; cur_asid = 4'h4;
        req_addr = 32'h5000_0000; req_kind = 2'b00; do_req("R6");
        pg_asid = 4'h4; do_req("R6");
        pg_asid_chk = 1'b0;

        // R7: guarded speculative.
        req_addr = 32'h2000_0000;
        page(2'b10, 1, 1, 1, 1, 1); req_spec = 1'b1; do_req("R7");
        pg_guard = 1'b0; do_req("R7");
        pg_guard = 1'b1; req_spec = 1'b0; do_req("R7");

        // R10: privilege beats read/write and guard.
        page(2'b00, 0, 0, 1, 1, 1); req_super = 1'b0; req_spec = 1'b1;
        req_kind = 2'b01; do_req("R10");
        req_super = 1'b1; do_req("R10");
        req_spec = 1'b0;

        // R9: bypass per traffic kind.
        cfg_ifetch_en = 1'b0;
        req_kind = 2'b10; req_super = 1'b0; do_req("R9");
        req_kind = 2'b00; do_req("R9");
        cfg_ifetch_en = 1'b1; cfg_data_en = 1'b0;
        req_kind = 2'b10; do_req("R9");
        req_kind = 2'b01; do_req("R9");
        cfg_data_en = 1'b1;

        // R8: permitted attribute passthrough.
        page(2'b10, 1, 1, 0, 1, 1); req_kind = 2'b00; do_req("R8");
        page(2'b10, 1, 1, 0, 0, 1); do_req("R8");

        // R11: no strobe and held result on an idle cycle.
        held = {rsp_fault, rsp_cause, rsp_cache_en, rsp_wthru};
        page(2'b00, 0, 0, 1, 0, 0);
        @(negedge clk);
        check("R11", {rsp_valid, rsp_fault, rsp_cause, rsp_cache_en, rsp_wthru},
              {1'b0, held});

        // Random mix.
        for (int n = 0; n < 600; n++) begin
            if (($urandom % 8) == 0)
                write_field(int'($urandom % 16), 2'($urandom));
            cfg_domain_mode = 1'($urandom);
            cfg_ifetch_en   = (($urandom % 8) != 0);
            cfg_data_en     = (($urandom % 8) != 0);
            req_addr    = $urandom;
            req_kind    = 2'($urandom);
            req_super   = 1'($urandom);
            req_spec    = 1'($urandom);
            cur_asid    = 4'($urandom % 3);
            pg_asid     = 4'($urandom % 3);
            pg_asid_chk = 1'($urandom);
            page(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
            do_req("R10");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule